// File: doc/BRIEF.md
# Synthesizer Loop Divider and Phase Detector

This block is the digital heart of a tuning synthesizer loop. A 15-bit programmable down-counter divides the oscillator clock after the external divide-by-16 prescaler. A fixed counter divides the reference clock down to the comparison rate. With the default ratio of 512, a 4 MHz reference gives a 7.8125 kHz comparison rate. The tuned frequency is therefore the programmed ratio times 16 times the comparison rate. A two-flop phase-frequency detector compares the two divided edges and produces pump-up and pump-down pulses. A lock qualifier turns the widths of those pulses into a lock flag.

Both clocks arrive as single-cycle enable strobes (`ref_tick_i`, `osc_tick_i`) in one synchronous clock domain. Four control bits shape the outputs. One disables the pump, one turns off the drive amplifier enable, one picks the pump current, and one routes the two internal compare strobes out to two port pins for test.

Top module: `synth_core`

## Requirements
- R1: With `osc_tick_i` strobed, `p7_o` (with `t1_i`=1) pulses once every `ratio_i` oscillator strobes, for any ratio from 1 to 32767. A ratio of 0 behaves as 1.
- R2: A new `ratio_i` value is taken only when the oscillator counter reaches its terminal count. A count already in progress completes with the old ratio.
- R3: The reference compare strobe occurs once every REF_DIV reference strobes. REF_DIV defaults to 512.
- R4: If the reference compare strobe leads, `pump_up_o` pulses. If the oscillator strobe leads, `pump_down_o` pulses. If the two strobes fall in the same cycle, neither output pulses. The two outputs are never high together.
- R5: `lock_o` rises at the fourth consecutive reference compare in which the pump pulse stayed shorter than 4 reference strobes. It rises exactly one cycle after that compare strobe and never earlier.
- R6: A compare window whose pump pulse reached 4 reference strobes clears `lock_o` at that compare.
- R7: With `t0_i`=1, `pump_up_o` and `pump_down_o` stay 0.
- R8: With `t1_i`=1, `p6_o` carries the reference compare strobe and `p7_o` carries the divided oscillator strobe. With `t1_i`=0, both stay 0.
- R9: `hi_cur_o` follows `cp_i`: 1 selects the high pump current and 0 the low current.
- R10: `amp_en_o` is 0 when `os_i` is 1 and 1 when `os_i` is 0.
- R11: While `rst_n` is low, and after its release until strobes arrive, the pump outputs, `lock_o`, `p6_o` and `p7_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick_i | input | 1 | One-cycle strobe per reference clock edge |
| osc_tick_i | input | 1 | One-cycle strobe per prescaled oscillator edge |
| ratio_i | input | 15 | Programmed oscillator division ratio |
| cp_i | input | 1 | Pump current select bit |
| t0_i | input | 1 | Pump disable bit |
| t1_i | input | 1 | Compare-signal test routing bit |
| os_i | input | 1 | Drive amplifier off bit |
| pump_up_o | output | 1 | Charge pump source pulse |
| pump_down_o | output | 1 | Charge pump sink pulse |
| hi_cur_o | output | 1 | High pump current select |
| amp_en_o | output | 1 | Drive amplifier enable |
| lock_o | output | 1 | Loop lock flag |
| p6_o | output | 1 | Test port carrying the reference compare strobe |
| p7_o | output | 1 | Test port carrying the divided oscillator strobe |

## Verification
The reference compare strobe and the divided oscillator strobe can land in the same cycle, which is what happens when the loop is locked. The bench provokes this by starting both strobe streams on the same edge with matching ratios. It then requires that neither pump output ever pulses and that the lock flag rises on the exact edge given by R5. Leading and lagging offsets of 2 and 6 cycles check the one-sided pulses and the pulse-width boundary. A ratio change in the middle of a count checks that the divider reload waits for its terminal count.

// File: rtl/synth_pkg.sv
package synth_pkg;
    localparam int DIV_W          = 15;
    localparam int DEF_REF_DIV    = 512;
    localparam int DEF_WIDTH_LIM  = 4;
    localparam int DEF_LOCK_COUNT = 4;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_st_t;
endpackage

// File: rtl/synth_div.sv
module synth_div #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [W-1:0] ratio_i,
    output logic         pulse_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pulse;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (tick_i) begin
            if (st_q.cnt == '0) begin
                // terminal count: emit strobe and take the current ratio
                st_d.pulse = 1'b1;
                st_d.cnt   = (ratio_i == '0) ? '0 : ratio_i - W'(1);
            end else begin
                st_d.cnt = st_q.cnt - W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/synth_pfd.sv
module synth_pfd
    import synth_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    input  logic div_i,
    output logic up_o,
    output logic dn_o
);
    pfd_st_t st_d, st_q;

    always_comb begin
        st_d.up = st_q.up | ref_i;
        st_d.dn = st_q.dn | div_i;
        if (st_d.up && st_d.dn) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up_o = st_q.up;
    assign dn_o = st_q.dn;
endmodule

// File: rtl/synth_lock.sv
module synth_lock #(
    parameter int WIDTH_LIM  = 4,
    parameter int LOCK_COUNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick_i,
    input  logic cmp_i,
    input  logic active_i,
    output logic lock_o
);
    localparam int WC_W = $clog2(WIDTH_LIM + 1);
    localparam int GC_W = $clog2(LOCK_COUNT + 1);
    localparam logic [WC_W-1:0] LIM_V  = WC_W'(WIDTH_LIM);
    localparam logic [GC_W-1:0] GOOD_V = GC_W'(LOCK_COUNT);

    typedef struct packed {
        logic [WC_W-1:0] width;
        logic            bad;
        logic [GC_W-1:0] good;
    } lock_st_t;

    lock_st_t st_d, st_q;
    logic     wide_now;

    always_comb begin
        st_d     = st_q;
        wide_now = active_i && (st_q.width == LIM_V);

        // pulse width in reference strobes, saturating at the limit
        if (!active_i)                             st_d.width = '0;
        else if (ref_tick_i && st_q.width != LIM_V) st_d.width = st_q.width + WC_W'(1);

        if (cmp_i) begin
            if (st_q.bad || wide_now)  st_d.good = '0;
            else if (st_q.good != GOOD_V) st_d.good = st_q.good + GC_W'(1);
            st_d.bad = 1'b0;
        end
        if (wide_now) st_d.bad = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_o = (st_q.good == GOOD_V);
endmodule

// File: rtl/synth_core.sv
module synth_core
    import synth_pkg::*;
#(
    parameter int REF_DIV    = DEF_REF_DIV,
    parameter int WIDTH_LIM  = DEF_WIDTH_LIM,
    parameter int LOCK_COUNT = DEF_LOCK_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick_i,
    input  logic             osc_tick_i,
    input  logic [DIV_W-1:0] ratio_i,
    input  logic             cp_i,
    input  logic             t0_i,
    input  logic             t1_i,
    input  logic             os_i,
    output logic             pump_up_o,
    output logic             pump_down_o,
    output logic             hi_cur_o,
    output logic             amp_en_o,
    output logic             lock_o,
    output logic             p6_o,
    output logic             p7_o
);
    localparam int REF_W = $clog2(REF_DIV + 1);
    localparam logic [REF_W-1:0] REF_RATIO = REF_W'(REF_DIV);

    logic ref_pulse_w, div_pulse_w, pfd_up_w, pfd_dn_w;

    synth_div #(.W(REF_W)) u_ref_div (
        .clk(clk), .rst_n(rst_n), .tick_i(ref_tick_i),
        .ratio_i(REF_RATIO), .pulse_o(ref_pulse_w)
    );

    synth_div #(.W(DIV_W)) u_osc_div (
        .clk(clk), .rst_n(rst_n), .tick_i(osc_tick_i),
        .ratio_i(ratio_i), .pulse_o(div_pulse_w)
    );

    synth_pfd u_pfd (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_pulse_w), .div_i(div_pulse_w),
        .up_o(pfd_up_w), .dn_o(pfd_dn_w)
    );

    synth_lock #(.WIDTH_LIM(WIDTH_LIM), .LOCK_COUNT(LOCK_COUNT)) u_lock (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick_i), .cmp_i(ref_pulse_w),
        .active_i(pfd_up_w | pfd_dn_w), .lock_o(lock_o)
    );

    assign pump_up_o   = pfd_up_w & ~t0_i;
    assign pump_down_o = pfd_dn_w & ~t0_i;
    assign hi_cur_o    = cp_i;
    assign amp_en_o    = ~os_i;
    assign p6_o        = t1_i & ref_pulse_w;
    assign p7_o        = t1_i & div_pulse_w;
endmodule

// File: rtl/synth_core_chk.sv
module synth_core_chk (
    input logic clk,
    input logic rst_n,
    input logic osc_tick_i,
    input logic ref_pulse_w,
    input logic div_pulse_w,
    input logic pfd_up_w,
    input logic pfd_dn_w,
    input logic lock_o
);
    assert_div_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse_w |-> $past(osc_tick_i));

    assert_pfd_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(pfd_up_w && pfd_dn_w));

    assert_up_after_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pfd_up_w) |-> $past(ref_pulse_w));

    assert_dn_after_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pfd_dn_w) |-> $past(div_pulse_w));

    assert_lock_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(ref_pulse_w));

    assert_lock_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> $past(ref_pulse_w));
endmodule

bind synth_core synth_core_chk chk (
    .clk(clk), .rst_n(rst_n), .osc_tick_i(osc_tick_i),
    .ref_pulse_w(ref_pulse_w), .div_pulse_w(div_pulse_w),
    .pfd_up_w(pfd_up_w), .pfd_dn_w(pfd_dn_w), .lock_o(lock_o)
);

// File: tb/synth_core_test.sv
module synth_core_test;
    localparam int R = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0, osc_tick = 1'b0;
    logic ref_en = 1'b0, osc_en = 1'b0, osc_half = 1'b0;
    logic [14:0] ratio = 15'd16;
    logic cp = 1'b0, t0 = 1'b0, t1 = 1'b0, os = 1'b0;
    logic up, dn, hic, amp, lk, p6, p7;
    logic f_up, f_dn, f_hic, f_amp, f_lk, f_p6, f_p7;
    int n_vec = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    synth_core #(.REF_DIV(R)) uut (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .osc_tick_i(osc_tick),
        .ratio_i(ratio), .cp_i(cp), .t0_i(t0), .t1_i(t1), .os_i(os),
        .pump_up_o(up), .pump_down_o(dn), .hi_cur_o(hic), .amp_en_o(amp),
        .lock_o(lk), .p6_o(p6), .p7_o(p7)
    );

    synth_core uut_fixed (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .osc_tick_i(osc_tick),
        .ratio_i(ratio), .cp_i(cp), .t0_i(t0), .t1_i(t1), .os_i(os),
        .pump_up_o(f_up), .pump_down_o(f_dn), .hi_cur_o(f_hic), .amp_en_o(f_amp),
        .lock_o(f_lk), .p6_o(f_p6), .p7_o(f_p7)
    );

    initial forever begin
        @(negedge clk);
        ref_tick = ref_en;
        osc_tick = osc_en & (osc_half ? ~osc_tick : 1'b1);
    end

    task automatic chk(input string rq, input longint act, input longint exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic logic sig(input int s);
        case (s)
            6:       return p6;
            7:       return p7;
            default: return f_p6;
        endcase
    endfunction

    task automatic gap(input int s, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sig(s) && n < 70000);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ref_en = 1'b0; osc_en = 1'b0; osc_half = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // offset > 0: reference strobes start first; offset < 0: oscillator first
    task automatic run_offset(input int offset, output int ups, output int dns, output logic lock_end);
        do_reset();
        @(posedge clk);
        if (offset >= 0) ref_en = 1'b1; else osc_en = 1'b1;
        repeat ((offset >= 0) ? offset : -offset) @(posedge clk);
        ref_en = 1'b1; osc_en = 1'b1;
        ups = 0; dns = 0;
        repeat (12 * R) begin
            @(negedge clk);
            if (up) ups++;
            if (dn) dns++;
        end
        lock_end = lk;
    endtask

    initial begin
        int p, t, ups, dns;
        logic le;
        do_reset();
        // R11: idle state after reset
        @(negedge clk);
        t1 = 1'b1;
        repeat (5) @(negedge clk);
        chk("R11 up", up, 0); chk("R11 dn", dn, 0); chk("R11 lock", lk, 0);
        chk("R11 p6", p6, 0); chk("R11 p7", p7, 0);

        // R9, R10: control pass-through over all combinations
        for (int k = 0; k < 4; k++) begin
            cp = k[0]; os = k[1];
            @(negedge clk);
            chk("R9 hi_cur", hic, k[0]);
            chk("R10 amp_en", amp, !k[1]);
        end
        cp = 1'b0; os = 1'b0;

        // R1: ratio sweep, full-rate strobes
        ref_en = 1'b1; osc_en = 1'b1;
        for (int n = 0; n <= 40; n++) begin
            ratio = 15'(n);
            gap(7, p); gap(7, p);
            chk($sformatf("R1 period ratio=%0d", n), p, (n == 0) ? 1 : n);
        end
        // R3: reference compare period on the small configuration
        gap(6, p); gap(6, p);
        chk("R3 compare period small", p, R);

        // R2: change mid-count does not truncate the running count
        ratio = 15'd40;
        gap(7, p); gap(7, p);
        t = 0;
        repeat (3) begin @(negedge clk); t++; end
        ratio = 15'd5;
        gap(7, p);
        chk("R2 old count completes", t + p, 40);
        gap(7, p);
        chk("R2 new ratio after terminal", p, 5);

        // R1: half-rate oscillator strobes
        osc_half = 1'b1;
        ratio = 15'd7;
        gap(7, p); gap(7, p); gap(7, p);
        chk("R1 half rate period", p, 14);
        osc_half = 1'b0;

        // R3: default configuration divides by 512
        gap(60, p); gap(60, p);
        chk("R3 compare period default", p, 512);

        // R1: largest ratio
        ratio = 15'd40;
        gap(7, p); gap(7, p);
        ratio = 15'd32767;
        gap(7, p); gap(7, p);
        chk("R1 max ratio", p, 32767);

        // R8: routing off
        t1 = 1'b0;
        t = 0;
        ratio = 15'd3;
        repeat (100) begin @(negedge clk); if (p6 || p7) t++; end
        chk("R8 ports quiet with t1=0", t, 0);
        t1 = 1'b1;

        // R5: exact lock timing with coincident strobes
        ratio = 15'(R);
        do_reset();
        @(posedge clk);
        ref_en = 1'b1; osc_en = 1'b1;
        @(negedge clk);
        repeat (3 * R) @(negedge clk);
        chk("R5 not locked before 4th compare", lk, 0);
        repeat (2) @(negedge clk);
        chk("R5 locked one cycle after 4th compare", lk, 1);

        // R6: frequency error clears lock
        ratio = 15'(R + 3);
        repeat (40 * R) @(negedge clk);
        chk("R6 lock lost on frequency error", lk, 0);
        ratio = 15'(R);

        // R4: coincident strobes, no pulses
        run_offset(0, ups, dns, le);
        chk("R4 coincident up", ups, 0); chk("R4 coincident dn", dns, 0);
        chk("R5 coincident lock", le, 1);

        // R4/R5: reference leads by 2
        run_offset(2, ups, dns, le);
        chk("R4 ref leads up seen", ups > 0, 1); chk("R4 ref leads no dn", dns, 0);
        chk("R5 narrow pulses lock", le, 1);

        // R4/R5: oscillator leads by 2
        run_offset(-2, ups, dns, le);
        chk("R4 osc leads dn seen", dns > 0, 1); chk("R4 osc leads no up", ups, 0);
        chk("R5 narrow dn pulses lock", le, 1);

        // R6: wide pulses prevent lock
        run_offset(6, ups, dns, le);
        chk("R6 wide pulses no lock", le, 0); chk("R4 wide up seen", ups > 0, 1);

        // R7: pump disabled
        t0 = 1'b1;
        run_offset(6, ups, dns, le);
        chk("R7 up gated", ups, 0); chk("R7 dn gated", dns, 0);
        t0 = 1'b0;

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog (all R): actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule